// File: doc/BRIEF.md
# Single-Wire Ratio-Coded Frame Receiver

This block listens to a single control line, already synchronized to the local clock, and decodes the programming frames a host sends on it once digital dimming mode is active. Each bit is a high phase followed by a low phase. Its value comes from which phase dominates: a low at least twice as long as the high is a 0, and a high at least twice as long as the low is a 1. A frame is two bytes, each sent most significant bit first. The first byte is a fixed address. The second is a data byte that holds an acknowledge request, two reserved bits and a 5-bit dimming level.

A valid frame loads the level register. The register maps through a three-slope table to a feedback reference in millivolts, and that value goes to the analog reference generator. If the data byte asks for it, the receiver pulls the line low for a fixed time shortly after the frame as an acknowledge. It does not decode the line while that pulse is pending or active. Every timing limit is a parameter counted in clock cycles. The defaults assume a 50 MHz clock.

Line protocol: a low of at least `END_CYC` cycles readies the receiver (end condition). For each byte, the first high phase is also the start condition and must last at least `START_CYC`. Each bit is decided at the rising edge that ends its low phase. After the eighth bit the line returns high briefly, then holds low for the end condition.

Top module: `swrx_frame_rx`

## Requirements
- R1: After reset the level code is 31, the millivolt output is 200 and the line pull-down is released.
- R2: A frame made of address 0x72 and a data byte with bits 6:5 equal to zero loads data bits 4:0 into the level code.
- R3: The millivolt output follows the level code: 0 for code 0, 5 for code 1, then +3 per code up to 38 at code 12, +6 per code up to 104 at code 23, and +12 per code up to 200 at code 31.
- R4: A bit is 0 when its low phase is at least twice its high phase and 1 when its high phase is at least twice its low phase. A bit that meets neither rule discards the frame and leaves the level unchanged.
- R5: A frame whose address byte is not 0x72 leaves the level unchanged.
- R6: A data byte with bit 6 or bit 5 set leaves the level unchanged.
- R7: A byte that ends with fewer or more than 8 bits discards the frame.
- R8: When data bit 7 is set, the pull-down asserts `ACK_DLY_CYC` cycles after the end condition is detected and stays asserted for exactly `ACK_CYC` cycles. When bit 7 is clear, it never asserts. The pull-down is only active while digital mode is enabled.
- R9: While the digital-mode enable is low, the line is ignored and the level does not change.
- R10: A bit phase shorter than `MIN_PH_CYC`, or a first high phase of a byte shorter than `START_CYC`, discards the frame.
- R11: A high of `END_CYC` cycles or longer in the middle of a frame discards that frame. A new end condition is then needed before the next address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Synchronized control line level |
| dig_en | input | 1 | Digital dimming mode is active |
| line_pd | output | 1 | Open-drain pull-down request for the acknowledge |
| level_code | output | 5 | Current dimming level code |
| fb_mv | output | 8 | Feedback reference in millivolts |

## Verification
The assertions assume that `dig_en` changes only between frames and that `line_in` is a clean, synchronized copy of the wire, with the block's own pull-down wired-AND into it. The bench builds `line_in` as exactly that AND of the host drive and `line_pd`, drives every phase on falling clock edges and, except where a test breaks a rule on purpose, keeps each phase inside the legal short and long windows. The deliberately broken frames each violate one rule at a time, which lets the discard path of each rule be seen on the level code.

// File: rtl/swrx_pkg.sv
package swrx_pkg;
  localparam int LVL_W = 5;
  localparam int MV_W  = 8;
  localparam logic [LVL_W-1:0] LVL_RESET = 5'd31;

  // breakpoints of the three-slope level table
  localparam int SEG1_END = 12;
  localparam int SEG2_END = 23;
  localparam int SEG1_BASE = 5;
  localparam int SEG2_BASE = SEG1_BASE + 3 * (SEG1_END - 1);
  localparam int SEG3_BASE = SEG2_BASE + 6 * (SEG2_END - SEG1_END);

  typedef enum logic [1:0] {ACK_IDLE, ACK_WAIT, ACK_DRIVE} ack_state_t;

  function automatic logic [MV_W-1:0] level_to_mv(input logic [LVL_W-1:0] code);
    int c;
    int v;
    c = int'(code);
    if (c == 0)              v = 0;
    else if (c <= SEG1_END)  v = SEG1_BASE + 3 * (c - 1);
    else if (c <= SEG2_END)  v = SEG2_BASE + 6 * (c - SEG1_END);
    else                     v = SEG3_BASE + 12 * (c - SEG2_END);
    return MV_W'(v);
  endfunction
endpackage

// File: rtl/swrx_phase_timer.sv
module swrx_phase_timer #(
  parameter int END_CYC = 20000,
  localparam int CW = $clog2(END_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          line_in,
  output logic          rise,
  output logic          fall,
  output logic [CW-1:0] dur,
  output logic          long_low,
  output logic          long_high
);
  logic          line_q;
  logic [CW-1:0] cnt;
  logic          edge_det;
  logic          hit;

  assign edge_det = active && (line_in != line_q);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      line_q <= 1'b1;
      cnt    <= '0;
    end else if (edge_det) begin
      line_q <= line_in;
      cnt    <= CW'(1);
    end else if (cnt != CW'(END_CYC)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit       = active && !edge_det && (cnt == CW'(END_CYC - 1));
  assign rise      = edge_det && line_in;
  assign fall      = edge_det && !line_in;
  assign dur       = cnt;
  assign long_low  = hit && !line_q;
  assign long_high = hit && line_q;
endmodule

// File: rtl/swrx_frame_dec.sv
module swrx_frame_dec
  import swrx_pkg::*;
#(
  parameter int CW         = 15,
  parameter int MIN_PH_CYC = 100,
  parameter int START_CYC  = 100,
  parameter logic [7:0] ADDR = 8'h72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             rise,
  input  logic             fall,
  input  logic [CW-1:0]    dur,
  input  logic             long_low,
  input  logic             long_high,
  output logic             wr_en,
  output logic [LVL_W-1:0] wr_code,
  output logic             ack_req
);
  logic          ready;
  logic          byte_sel;
  logic [3:0]    nbits;
  logic [7:0]    sh;
  logic [CW-1:0] hi_len;
  logic          have_hi;
  logic          bad;
  logic          is_zero;
  logic          is_one;
  logic          too_short;

  always_comb begin
    is_zero   = {1'b0, dur}    >= {hi_len, 1'b0};
    is_one    = {1'b0, hi_len} >= {dur, 1'b0};
    too_short = (hi_len < CW'(MIN_PH_CYC)) || (dur < CW'(MIN_PH_CYC));
  end

  always_ff @(posedge clk) begin
    wr_en   <= 1'b0;
    ack_req <= 1'b0;
    if (rst || !active) begin
      ready    <= 1'b0;
      byte_sel <= 1'b0;
      nbits    <= '0;
      bad      <= 1'b0;
      have_hi  <= 1'b0;
      sh       <= '0;
      hi_len   <= '0;
      wr_code  <= '0;
    end else if (long_high) begin
      ready    <= 1'b0;
      byte_sel <= 1'b0;
      nbits    <= '0;
      bad      <= 1'b0;
      have_hi  <= 1'b0;
    end else if (long_low) begin
      if (ready && !bad && nbits == 4'd8) begin
        if (!byte_sel) begin
          byte_sel <= (sh == ADDR);
        end else begin
          byte_sel <= 1'b0;
          if (sh[6:5] == 2'b00) begin
            wr_en   <= 1'b1;
            wr_code <= sh[LVL_W-1:0];
            ack_req <= sh[7];
          end
        end
      end else if (nbits != 4'd0 || bad) begin
        byte_sel <= 1'b0;
      end
      ready   <= 1'b1;
      nbits   <= '0;
      bad     <= 1'b0;
      have_hi <= 1'b0;
    end else if (ready && fall) begin
      hi_len  <= dur;
      have_hi <= 1'b1;
      if (nbits == 4'd0 && dur < CW'(START_CYC)) bad <= 1'b1;
    end else if (ready && rise && have_hi) begin
      if (nbits == 4'd8) begin
        bad <= 1'b1;
      end else begin
        nbits <= nbits + 1'b1;
        if (too_short)    bad <= 1'b1;
        else if (is_zero) sh  <= {sh[6:0], 1'b0};
        else if (is_one)  sh  <= {sh[6:0], 1'b1};
        else              bad <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swrx_ack_gen.sv
module swrx_ack_gen
  import swrx_pkg::*;
#(
  parameter int ACK_DLY_CYC = 100,
  parameter int ACK_CYC     = 25600,
  localparam int TMAX = (ACK_CYC > ACK_DLY_CYC) ? ACK_CYC : ACK_DLY_CYC,
  localparam int TW   = $clog2(TMAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic req,
  output logic pd,
  output logic busy
);
  ack_state_t    st;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st  <= ACK_IDLE;
      tmr <= '0;
      pd  <= 1'b0;
    end else begin
      case (st)
        ACK_IDLE: if (req) begin
          st  <= ACK_WAIT;
          tmr <= TW'(1);
        end
        ACK_WAIT: if (tmr == TW'(ACK_DLY_CYC)) begin
          st  <= ACK_DRIVE;
          tmr <= TW'(1);
          pd  <= 1'b1;
        end else begin
          tmr <= tmr + 1'b1;
        end
        ACK_DRIVE: if (tmr == TW'(ACK_CYC)) begin
          st <= ACK_IDLE;
          pd <= 1'b0;
        end else begin
          tmr <= tmr + 1'b1;
        end
        default: st <= ACK_IDLE;
      endcase
    end
  end

  assign busy = (st != ACK_IDLE);
endmodule

// File: rtl/swrx_level_map.sv
module swrx_level_map
  import swrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_code,
  output logic [LVL_W-1:0] level,
  output logic [MV_W-1:0]  mv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= LVL_RESET;
      mv    <= level_to_mv(LVL_RESET);
    end else begin
      if (wr_en) level <= wr_code;
      mv <= level_to_mv(level);
    end
  end
endmodule

// File: rtl/swrx_frame_rx.sv
module swrx_frame_rx
  import swrx_pkg::*;
#(
  parameter int MIN_PH_CYC  = 100,
  parameter int START_CYC   = 100,
  parameter int END_CYC     = 20000,
  parameter int ACK_DLY_CYC = 100,
  parameter int ACK_CYC     = 25600,
  parameter logic [7:0] ADDR = 8'h72,
  localparam int CW = $clog2(END_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic             dig_en,
  output logic             line_pd,
  output logic [LVL_W-1:0] level_code,
  output logic [MV_W-1:0]  fb_mv
);
  logic             rx_active;
  logic             ack_busy;
  logic             rise, fall, long_low, long_high;
  logic [CW-1:0]    dur;
  logic             wr_en, ack_req;
  logic [LVL_W-1:0] wr_code;

  // own acknowledge is masked from decoding
  assign rx_active = dig_en && !ack_busy;

  swrx_phase_timer #(.END_CYC(END_CYC)) u_timer (
    .clk(clk), .rst(rst), .active(rx_active), .line_in(line_in),
    .rise(rise), .fall(fall), .dur(dur),
    .long_low(long_low), .long_high(long_high)
  );

  swrx_frame_dec #(
    .CW(CW), .MIN_PH_CYC(MIN_PH_CYC), .START_CYC(START_CYC), .ADDR(ADDR)
  ) u_dec (
    .clk(clk), .rst(rst), .active(rx_active),
    .rise(rise), .fall(fall), .dur(dur),
    .long_low(long_low), .long_high(long_high),
    .wr_en(wr_en), .wr_code(wr_code), .ack_req(ack_req)
  );

  swrx_ack_gen #(.ACK_DLY_CYC(ACK_DLY_CYC), .ACK_CYC(ACK_CYC)) u_ack (
    .clk(clk), .rst(rst), .active(dig_en), .req(ack_req),
    .pd(line_pd), .busy(ack_busy)
  );

  swrx_level_map u_map (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .level(level_code), .mv(fb_mv)
  );
endmodule

// File: rtl/swrx_frame_rx_chk.sv
module swrx_frame_rx_chk #(
  parameter int ACK_CYC = 25600,
  localparam int RW = $clog2(ACK_CYC + 2)
) (
  input logic       clk,
  input logic       rst,
  input logic       dig_en,
  input logic       line_pd,
  input logic [4:0] level_code,
  input logic [7:0] fb_mv
);
  logic [RW-1:0] pd_run;

  always_ff @(posedge clk) begin
    if (rst || !line_pd) pd_run <= '0;
    else if (pd_run != {RW{1'b1}}) pd_run <= pd_run + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (level_code == 5'd31 && fb_mv == 8'd200 && !line_pd));

  // R3
  mv_range_chk: assert property (@(posedge clk) disable iff (rst)
    fb_mv <= 8'd200);

  // R8
  ack_len_chk: assert property (@(posedge clk) disable iff (rst)
    line_pd |-> (pd_run < RW'(ACK_CYC)));

  // R8
  ack_off_chk: assert property (@(posedge clk) disable iff (rst)
    !dig_en |=> !line_pd);

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dig_en && $past(!dig_en)) |=> $stable(level_code));
endmodule

bind swrx_frame_rx swrx_frame_rx_chk #(.ACK_CYC(ACK_CYC)) u_chk (
  .clk(clk), .rst(rst), .dig_en(dig_en), .line_pd(line_pd),
  .level_code(level_code), .fb_mv(fb_mv)
);

// File: tb/tb_swrx_frame_rx.sv
module tb_swrx_frame_rx;
  localparam int MIN_PH = 4;
  localparam int START  = 8;
  localparam int ENDC   = 64;
  localparam int ADLY   = 5;
  localparam int ACKC   = 40;
  localparam int NVEC   = 10;

  // {ack request, level code, expected millivolts}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  8'd0},   {1'b0, 5'd1,  8'd5},
    {1'b1, 5'd12, 8'd38},  {1'b0, 5'd13, 8'd44},
    {1'b0, 5'd23, 8'd104}, {1'b1, 5'd24, 8'd116},
    {1'b0, 5'd7,  8'd23},  {1'b0, 5'd18, 8'd74},
    {1'b1, 5'd27, 8'd152}, {1'b0, 5'd31, 8'd200}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host = 1'b1;
  logic dig_en = 1'b0;
  logic line_pd;
  logic [4:0] level_code;
  logic [7:0] fb_mv;
  wire line_in = host & ~line_pd;

  int checks = 0;
  int errors = 0;
  int pd_cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  swrx_frame_rx #(
    .MIN_PH_CYC(MIN_PH), .START_CYC(START), .END_CYC(ENDC),
    .ACK_DLY_CYC(ADLY), .ACK_CYC(ACKC)
  ) dut (
    .clk(clk), .rst(rst), .line_in(line_in), .dig_en(dig_en),
    .line_pd(line_pd), .level_code(level_code), .fb_mv(fb_mv)
  );

  always @(negedge clk) if (line_pd) pd_cycles++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    host = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input int nb, input int bad_i,
                           input int bh, input int bl);
    for (int i = 0; i < nb; i++) begin
      logic b;
      int h, l;
      b = (i < 8) ? v[7-i] : 1'b0;
      if (i == 0) begin h = b ? 24 : 10; l = b ? 10 : 24; end
      else        begin h = b ? 12 : 5;  l = b ? 5 : 12;  end
      if (i == bad_i) begin h = bh; l = bl; end
      hold(1'b1, h);
      hold(1'b0, l);
    end
    hold(1'b1, 5);
    hold(1'b0, ENDC + 8);
  endtask

  task automatic frame_x(input logic [7:0] a, input logic [7:0] d, input int nb,
                         input int bad_i, input int bh, input int bl);
    pd_cycles = 0;
    hold(1'b0, ENDC + 8);
    send_byte(a, 8, -1, 0, 0);
    send_byte(d, nb, bad_i, bh, bl);
    hold(1'b0, ADLY + ACKC + 10);
    hold(1'b1, 10);
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] d);
    frame_x(a, d, 8, -1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 level", level_code, 31);
    chk("R1 mv", fb_mv, 200);
    chk("R1 pd", line_pd, 0);
    dig_en = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      logic ackb;
      logic [4:0] code;
      logic [7:0] mv;
      {ackb, code, mv} = VEC[k];
      frame(8'h72, {ackb, 2'b00, code});
      chk("R2 level", level_code, code);
      chk("R3 mv", fb_mv, mv);
      chk("R8 ack cycles", pd_cycles, ackb ? ACKC : 0);
    end

    frame(8'h72, 8'h09);
    chk("R4 baseline", level_code, 9);
    frame(8'h73, 8'h03);
    chk("R5 address mismatch", level_code, 9);
    frame(8'h72, 8'h23);
    chk("R6 reserved bit5", level_code, 9);
    frame(8'h72, 8'h43);
    chk("R6 reserved bit6", level_code, 9);
    frame_x(8'h72, 8'h03, 8, 3, 6, 9);
    chk("R4 ratio below 2:1", level_code, 9);
    frame_x(8'h72, 8'h03, 8, 3, 12, 3);
    chk("R10 short phase", level_code, 9);
    frame_x(8'h72, 8'h03, 8, 0, 6, 14);
    chk("R10 short start", level_code, 9);
    frame_x(8'h72, 8'h03, 7, -1, 0, 0);
    chk("R7 seven bits", level_code, 9);
    frame_x(8'h72, 8'h03, 9, -1, 0, 0);
    chk("R7 nine bits", level_code, 9);
    frame(8'h72, 8'h81);
    chk("R4 mixed bits", level_code, 1);
    chk("R8 ack after mixed", pd_cycles, ACKC);

    // R11: long idle high between address and data
    pd_cycles = 0;
    hold(1'b0, ENDC + 8);
    send_byte(8'h72, 8, -1, 0, 0);
    hold(1'b1, ENDC + 6);
    hold(1'b0, ENDC + 8);
    send_byte(8'h86, 8, -1, 0, 0);
    hold(1'b0, ADLY + ACKC + 10);
    hold(1'b1, 10);
    chk("R11 idle abort", level_code, 1);
    chk("R11 no ack", pd_cycles, 0);

    // R9: receiver disabled
    dig_en = 1'b0;
    frame(8'h72, 8'h85);
    chk("R9 disabled level", level_code, 1);
    chk("R9 disabled ack", pd_cycles, 0);
    dig_en = 1'b1;
    frame(8'h72, 8'h05);
    chk("R9 re-enabled", level_code, 5);
    chk("R3 code5", fb_mv, 17);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 re-reset level", level_code, 31);
    chk("R1 re-reset mv", fb_mv, 200);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule